// File: doc/BRIEF.md
# Byte-Masked Single-Port RAM

A synchronous single-port memory with one clock, a clock enable and a registered read-data output. Each word is split into lanes of nine bits, and a per-lane enable vector selects which lanes a write actually changes. The read-data register is loaded only when a read is requested, so it holds its last read result across writes made with read disabled.

A build-time parameter picks what a read returns when it hits the word being written in the same cycle. In new-data mode the output merges the freshly written lanes with the stored lanes that the mask left alone. In old-data mode it shows the word as it was before the write. An address-stall input freezes the internally latched address, so a stalled access reuses the previous address whatever the address input carries. Dropping the clock enable freezes the block entirely. An active-low synchronous reset clears the output register and the latched address and leaves the stored words untouched.

Top module: `bmask_sp_ram`

## Requirements
- R1: Lane enables are active high, one bit per lane: bit 0 governs lane 0 (data bits 8:0) and bit 1 governs lane 1 (bits 17:9); an enabled lane takes the write data of its own bit range.
- R2: Any lane-enable combination is legal; a lane whose enable bit is 0 keeps its stored value during a write, and the pattern 2'b00 changes nothing.
- R3: With lane enables 2'b11, the write enable alone writes the whole 18-bit word.
- R4: While the read enable is 0, the read data holds the result of the most recent enabled read, and a write in that cycle still updates memory.
- R5: In new-data mode, a read that coincides with a write returns, one edge later, the written lanes where the enable is 1 and the stored lanes where it is 0.
- R6: In old-data mode, a read that coincides with a write returns, one edge later, the word held at that address before the write.
- R7: While address-stall is 1, the address input is ignored and both reads and writes use the previously latched address.
- R8: While the clock enable is 0, no write, read, address latch or output update takes place.
- R9: A clock edge with rst_n at 0 clears the read data to zero and the latched address to zero; memory contents are kept.
- R10: A read with no write returns the stored word at the edge after the request (one cycle of latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low; clears output and latched address |
| ce | input | 1 | Clock enable; 0 freezes the whole block |
| addr | input | AW (8) | Word address |
| wdata | input | LANES*LANE_W (18) | Write data |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request; 0 holds the read data |
| lane_en | input | LANES (2) | Per-lane write enables, bit i for lane i |
| addr_stall | input | 1 | 1 reuses the latched address |
| rdata | output | LANES*LANE_W (18) | Registered read data |

## Verification
A read and a write to the same word fall in the same cycle whenever both enables are high, and the lane mask decides which parts of that word the write touches. The bench provokes this with all four lane-enable patterns on previously written words, driving a new-data and an old-data instance side by side. Each output is judged against a reference array that yields the merged word for new-data mode and the pre-write word for old-data mode, and later plain reads confirm what actually landed in memory.

// File: rtl/bmsp_pkg.sv
// Shared types for the byte-masked single-port RAM.
// Assumes: nothing beyond the build parameters of the instantiating module.
package bmsp_pkg;

    // What a read returns when it hits the word being written in the same cycle.
    typedef enum logic {
        RDW_NEW_DATA = 1'b0,
        RDW_OLD_DATA = 1'b1
    } rdw_mode_e;

endpackage

// File: rtl/bmsp_addr_stage.sv
// Address stage: holds the latched address and selects between the address
// input and the latched value when a stall is requested.
// Assumes: a synchronous active-low reset; ce gates every update.
module bmsp_addr_stage #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce,
    input  logic          stall,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] addr_eff,
    output logic [AW-1:0] addr_q
);

    // Feedback mux: a stall reuses the latched address.
    always_comb begin
        addr_eff = stall ? addr_q : addr_in;
    end

    // Latch the address used by this access, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (ce) begin
            addr_q <= addr_eff;
        end
    end

    // R7: a stalled, enabled cycle leaves the latched address unchanged.
    a_r7_stall_keeps_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && stall) |=> (addr_q == $past(addr_q)));

    // R7: an unstalled, enabled cycle latches the address input.
    a_r7_unstalled_takes_input: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !stall) |=> (addr_q == $past(addr_in)));

    // R8: with ce low the latched address does not move.
    a_r8_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> $stable(addr_q));

endmodule

// File: rtl/bmsp_lane_bank.sv
// One lane of storage: a DEPTH x LANE_W array written when its lane is
// enabled, plus the read-during-write forwarding chosen by MODE.
// Assumes: addr is already the effective (stall-resolved) address.
module bmsp_lane_bank
    import bmsp_pkg::*;
#(
    parameter int        LANE_W = 9,
    parameter int        AW     = 8,
    parameter rdw_mode_e MODE   = RDW_NEW_DATA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              wr,
    input  logic [AW-1:0]     addr,
    input  logic [LANE_W-1:0] wdata,
    output logic [LANE_W-1:0] old_q,
    output logic [LANE_W-1:0] fwd_q
);

    localparam int DEPTH = 1 << AW;

    logic [LANE_W-1:0] mem [DEPTH];

    // Store the lane data when this lane is written in an enabled cycle.
    always_ff @(posedge clk) begin
        if (ce && wr) begin
            mem[addr] <= wdata;
        end
    end

    // Stored value at the accessed address, before any write of this cycle.
    always_comb begin
        old_q = mem[addr];
    end

    // Select the read-during-write variant for this lane.
    generate
        if (MODE == RDW_NEW_DATA) begin : g_new
            // Flow the write data through when this lane is written.
            always_comb begin
                fwd_q = wr ? wdata : old_q;
            end
        end else begin : g_old
            // Always return the pre-write content.
            always_comb begin
                fwd_q = old_q;
            end
        end
    endgenerate

    // R1: a written lane holds the write data afterwards.
    a_r1_lane_written: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && wr) |=> (mem[$past(addr)] == $past(wdata)));

endmodule

// File: rtl/bmsp_out_reg.sv
// Output register: loads the read word on an enabled read, otherwise holds.
// Assumes: synchronous active-low reset that clears it to zero.
module bmsp_out_reg #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ce,
    input  logic         rd,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Capture read data on an enabled read, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (ce && rd) begin
            q <= d;
        end
    end

    // R4: read enable low keeps the output.
    a_r4_hold_when_rd_off: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(q));

    // R8: clock enable low keeps the output.
    a_r8_hold_when_ce_off: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> $stable(q));

    // R9: a reset edge leaves the output at zero.
    a_r9_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (q == '0));

endmodule

// File: rtl/bmask_sp_ram.sv
// Byte-masked single-port RAM: one address stage, one storage bank per
// lane, and a registered read output. MODE selects new-data or old-data
// behaviour on a read that coincides with a write to the same word.
// Assumes: depth is a power of two (2**AW); memory contents are not reset.
module bmask_sp_ram
    import bmsp_pkg::*;
#(
    parameter int        LANE_W = 9,
    parameter int        LANES  = 2,
    parameter int        AW     = 8,
    parameter rdw_mode_e MODE   = RDW_NEW_DATA
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ce,
    input  logic [AW-1:0]           addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic [LANES-1:0]        lane_en,
    input  logic                    addr_stall,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int W = LANES * LANE_W;

    logic [AW-1:0] addr_eff;
    logic [AW-1:0] addr_q;
    logic [W-1:0]  old_word;
    logic [W-1:0]  rd_word;

    bmsp_addr_stage #(.AW(AW)) addr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce      (ce),
        .stall   (addr_stall),
        .addr_in (addr),
        .addr_eff(addr_eff),
        .addr_q  (addr_q)
    );

    // One storage bank and its checks per lane.
    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            logic lane_wr;

            // Lane is written only when the write and its enable bit are both set.
            always_comb begin
                lane_wr = wr_en && lane_en[i];
            end

            bmsp_lane_bank #(
                .LANE_W(LANE_W),
                .AW    (AW),
                .MODE  (MODE)
            ) bank_i (
                .clk  (clk),
                .rst_n(rst_n),
                .ce   (ce),
                .wr   (lane_wr),
                .addr (addr_eff),
                .wdata(wdata[i*LANE_W +: LANE_W]),
                .old_q(old_word[i*LANE_W +: LANE_W]),
                .fwd_q(rd_word[i*LANE_W +: LANE_W])
            );

            if (MODE == RDW_NEW_DATA) begin : g_chk_new
                // R5: an enabled lane flows its write data to the output.
                a_r5_new_lane_forward: assert property (@(posedge clk) disable iff (!rst_n)
                    (ce && rd_en && wr_en && lane_en[i])
                    |=> (rdata[i*LANE_W +: LANE_W] == $past(wdata[i*LANE_W +: LANE_W])));
            end else begin : g_chk_old
                // R6: the output shows the lane as stored before the write.
                a_r6_old_lane_shown: assert property (@(posedge clk) disable iff (!rst_n)
                    (ce && rd_en)
                    |=> (rdata[i*LANE_W +: LANE_W] == $past(old_word[i*LANE_W +: LANE_W])));
            end
        end
    endgenerate

    bmsp_out_reg #(.W(W)) out_i (
        .clk  (clk),
        .rst_n(rst_n),
        .ce   (ce),
        .rd   (rd_en),
        .d    (rd_word),
        .q    (rdata)
    );

endmodule

// File: tb/bmask_sp_ram_tb_top.sv
// Bench: drives a new-data and an old-data instance with the same stimulus
// and compares both outputs with a reference array model.
module bmask_sp_ram_tb_top;
    import bmsp_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce = 1'b0;
    logic [7:0]  addr = '0;
    logic [17:0] wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  lane_en = '0;
    logic        addr_stall = 1'b0;
    logic [17:0] q_new;
    logic [17:0] q_old;

    int n_tests = 0;
    int n_fail  = 0;

    // Reference state
    logic [17:0] ref_mem [256];
    logic [7:0]  ref_addr = '0;
    logic [17:0] exp_new = '0;
    logic [17:0] exp_old = '0;

    always #10 clk = ~clk;

    bmask_sp_ram #(.MODE(RDW_NEW_DATA)) dut_i (
        .clk(clk), .rst_n(rst_n), .ce(ce), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .lane_en(lane_en),
        .addr_stall(addr_stall), .rdata(q_new)
    );

    bmask_sp_ram #(.MODE(RDW_OLD_DATA)) dut_old_i (
        .clk(clk), .rst_n(rst_n), .ce(ce), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .lane_en(lane_en),
        .addr_stall(addr_stall), .rdata(q_old)
    );

    typedef struct packed {
        logic        we;
        logic        rd;
        logic [1:0]  be;
        logic [7:0]  a;
        logic [17:0] wd;
    } vec_t;

    // Stimulus table; expected results come from the reference model.
    localparam vec_t TBL [15] = '{
        '{1'b1, 1'b0, 2'b11, 8'd10, 18'h1A5C3},
        '{1'b1, 1'b0, 2'b11, 8'd11, 18'h2B6D4},
        '{1'b1, 1'b0, 2'b11, 8'd12, 18'h07E81},
        '{1'b1, 1'b0, 2'b11, 8'd13, 18'h3F00F},
        '{1'b0, 1'b1, 2'b11, 8'd10, 18'h00000},
        '{1'b1, 1'b1, 2'b00, 8'd11, 18'h3FFFF},
        '{1'b1, 1'b1, 2'b01, 8'd12, 18'h15555},
        '{1'b1, 1'b1, 2'b10, 8'd13, 18'h2AAAA},
        '{1'b1, 1'b1, 2'b11, 8'd10, 18'h00F0F},
        '{1'b0, 1'b1, 2'b11, 8'd11, 18'h00000},
        '{1'b0, 1'b1, 2'b11, 8'd12, 18'h00000},
        '{1'b0, 1'b1, 2'b11, 8'd13, 18'h00000},
        '{1'b0, 1'b1, 2'b11, 8'd10, 18'h00000},
        '{1'b1, 1'b0, 2'b01, 8'd11, 18'h12345},
        '{1'b0, 1'b1, 2'b00, 8'd11, 18'h00000}
    };

    task automatic chk(input string tag, input logic [17:0] act, input logic [17:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One clock: drive at negedge, update model at posedge, return at negedge.
    task automatic cyc(input logic c, input logic st, input logic we, input logic rd,
                       input logic [1:0] be, input logic [7:0] a, input logic [17:0] wd);
        logic [7:0]  ea;
        logic [17:0] old;
        logic [17:0] merged;
        ce = c; addr_stall = st; wr_en = we; rd_en = rd; lane_en = be; addr = a; wdata = wd;
        @(posedge clk);
        if (c) begin
            ea = st ? ref_addr : a;
            ref_addr = ea;
            old = ref_mem[ea];
            merged = old;
            if (we && be[0]) merged[8:0]  = wd[8:0];
            if (we && be[1]) merged[17:9] = wd[17:9];
            if (rd) begin
                exp_new = merged;
                exp_old = old;
            end
            ref_mem[ea] = merged;
        end
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; ce = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr_stall = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        ref_addr = '0; exp_new = '0; exp_old = '0;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) ref_mem[i] = '0;
        @(negedge clk);
        do_reset();
        chk("R9 reset new", q_new, 18'h0);
        chk("R9 reset old", q_old, 18'h0);

        // Table walk: covers R5 and R6 with every lane pattern, plus R10 reads.
        for (int i = 0; i < 15; i++) begin
            cyc(1'b1, 1'b0, TBL[i].we, TBL[i].rd, TBL[i].be, TBL[i].a, TBL[i].wd);
            chk("R5 table new-data", q_new, exp_new);
            chk("R6 table old-data", q_old, exp_old);
        end

        // R10: plain read latency
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 2'b00, 8'd12, 18'h0);
        chk("R10 read", q_new, 18'h07E81 & 18'h3FE00 | 18'h15555 & 18'h001FF);

        // R1: lane 0 only
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 2'b11, 8'd20, 18'h00000);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 2'b01, 8'd20, 18'h3FFFF);
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 2'b00, 8'd20, 18'h0);
        chk("R1 lane0 mapping", q_new, 18'h001FF);

        // R2: empty mask writes nothing
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 8'd20, 18'h00000);
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 2'b00, 8'd20, 18'h0);
        chk("R2 empty mask", q_old, 18'h001FF);

        // R3: full mask writes whole word
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 2'b11, 8'd20, 18'h2468A);
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 2'b00, 8'd20, 18'h0);
        chk("R3 full word", q_new, 18'h2468A);

        // R4: write with read off holds output, write still lands
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 2'b11, 8'd20, 18'h00000);
        chk("R4 hold", q_new, 18'h2468A);
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 2'b00, 8'd20, 18'h0);
        chk("R4 write landed", q_old, 18'h00000);

        // R7: stall reuses latched address for read and write
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 2'b00, 8'd10, 18'h0);
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 2'b00, 8'd20, 18'h0);
        chk("R7 stalled read", q_new, 18'h00F0F);
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 2'b11, 8'd21, 18'h11111);
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 2'b00, 8'd10, 18'h0);
        chk("R7 stalled write", q_new, 18'h11111);

        // R8: clock enable low blocks everything
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 2'b11, 8'd10, 18'h00000);
        chk("R8 output frozen", q_new, 18'h11111);
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 2'b00, 8'd20, 18'h0);
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 2'b00, 8'd10, 18'h0);
        chk("R8 no write", q_old, 18'h11111);
        chk("R8 model", q_new, exp_new);

        // R9: reset mid-run clears output, keeps memory
        do_reset();
        chk("R9 output cleared", q_new, 18'h0);
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 2'b00, 8'd10, 18'h0);
        chk("R9 memory kept", q_old, 18'h11111);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule